// File: doc/BRIEF.md
# Write-Once Snooping Coherence Controller

This block models a small shared-memory system in which several processors each own a tiny, fully associative cache. Each cache line holds one byte. All of them sit in front of one internal byte-wide main memory. The coherence rules follow a four-state write-once scheme. A clean line that is written for the first time sends the write on to memory and becomes reserved. Every later write to that line stays in the cache and makes the line dirty.

The controller accepts one request at a time. A request names the processor, the direction (read or write), the address and the write byte. The controller then works through the request in a few cycles:
- It looks the address up in the requester's cache.
- It snoops the other caches for copies.
- It writes back a dirty victim or a dirty remote copy where needed.
- It commits the new line states.

When the request is finished, a done pulse returns the byte that was read or written. A counter of main-memory accesses is exposed so that traffic can be observed at the ports. When a line must be replaced, the controller takes a free (invalid) entry first. If there is none, it takes the least-used entry.

Top module: `woc_top`

## Requirements
- R1: After reset every line is invalid, main memory holds zero everywhere, memAccessCount is 0, reqReady is 1 and doneValid is 0.
- R2: A read hit returns the cached byte, leaves every line state unchanged and makes no memory access.
- R3: On a read miss with no dirty copy in another cache, the byte is fetched from memory (one access) and installed as valid. Any reserved copy elsewhere drops to valid.
- R4: On a read miss where another cache holds the address dirty, the data comes from that cache and is written to memory (one access). Both copies end valid.
- R5: A write hit on a valid line updates the cached byte and memory (one access), invalidates all other copies and leaves the line reserved.
- R6: A write hit on a reserved or dirty line updates only the cached byte, makes no memory access and leaves the line dirty.
- R7: On a write miss, copies in the other caches are invalidated and the byte is installed dirty in the requester. Memory is not touched unless R8 or R9 applies.
- R8: If a write miss finds another cache holding the address dirty, that copy is first written back to memory (one access) and then invalidated.
- R9: An evicted victim is written back to memory (one access) only when it is dirty. Valid or reserved victims are overwritten without any access.
- R10: The victim is the lowest-numbered invalid entry of the requester's cache. If no entry is invalid, it is the entry with the smallest use count, lowest index on a tie. A fill sets the use count to 1, and each hit adds 1, saturating.
- R11: reqReady is high only while idle, and a request is taken when reqValid and reqReady are both high. doneValid is a one-cycle pulse. With it, doneData carries the read byte, or the written byte for a write.
- R12: memAccessCount rises by exactly one for every main-memory read or write the controller performs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqCpu | input | CPU_W | Index of the requesting processor/cache |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address |
| reqData | input | DATA_W | Byte to write |
| doneValid | output | 1 | One-cycle completion pulse |
| doneData | output | DATA_W | Byte read or written by the completed request |
| memAccessCount | output | CNT_W | Running count of main-memory accesses |

## Verification
The request sequence covers several patterns:
- The same address is passed among three caches. This walks one line through every state: written dirty by one cache, supplied to a reader, written through once, written locally twice, then stolen by a write miss. The memory count at each completion distinguishes write-through from a local write, and a snooped supply from a memory fetch.
- One cache is filled beyond its size, with a chosen mix of hits. This separates least-used replacement from index order, and dirty-victim write-back from silent overwrite.
- Later reads from other caches return the written-back bytes. This shows that data really reached memory, and that invalidated copies are no longer hit.

// File: rtl/woc_pkg.sv
package woc_pkg;

  typedef enum logic [1:0] {
    ST_INV   = 2'd0,
    ST_VALID = 2'd1,
    ST_RESV  = 2'd2,
    ST_DIRTY = 2'd3
  } line_state_t;

  typedef enum logic [2:0] {
    FS_IDLE   = 3'd0,
    FS_DECIDE = 3'd1,
    FS_EVICT  = 3'd2,
    FS_SNOOP  = 3'd3,
    FS_COMMIT = 3'd4
  } fsm_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic evictWb;
    logic snoopWb;
    logic commit;
  } ctrl_strobe_t;

  // lookup results from datapath to control
  typedef struct packed {
    logic ownHit;
    logic otherDirty;
    logic victimDirty;
  } dp_flags_t;

endpackage

// File: rtl/woc_control.sv
module woc_control
  import woc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  dp_flags_t    flags,
  output logic         reqReady,
  output ctrl_strobe_t strobe
);

  fsm_state_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= FS_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    strobe   = '0;
    reqReady = 1'b0;
    unique case (stateQ)
      FS_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          stateD          = FS_DECIDE;
        end
      end
      FS_DECIDE: begin
        if (!flags.ownHit && flags.victimDirty)     stateD = FS_EVICT;
        else if (!flags.ownHit && flags.otherDirty) stateD = FS_SNOOP;
        else                                        stateD = FS_COMMIT;
      end
      FS_EVICT: begin
        strobe.evictWb = 1'b1;
        stateD = flags.otherDirty ? FS_SNOOP : FS_COMMIT;
      end
      FS_SNOOP: begin
        strobe.snoopWb = 1'b1;
        stateD         = FS_COMMIT;
      end
      FS_COMMIT: begin
        strobe.commit = 1'b1;
        stateD        = FS_IDLE;
      end
      default: stateD = FS_IDLE;
    endcase
  end

  // a remote write-back is always followed by the commit
  AST_SNOOP_THEN_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == FS_SNOOP) |=> (stateQ == FS_COMMIT)); // R8

  // no request is taken while a previous one is in progress
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchReq |=> !reqReady); // R11

endmodule

// File: rtl/woc_datapath.sv
module woc_datapath
  import woc_pkg::*;
#(
  parameter int NUM_CACHES = 3,
  parameter int ENTRIES    = 4,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int USE_W      = 3,
  parameter int CNT_W      = 16,
  parameter int CPU_W      = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [CPU_W-1:0]  reqCpu,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output dp_flags_t         flags,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneData,
  output logic [CNT_W-1:0]  memAccessCount
);

  localparam int WAY_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int MEM_DEPTH = 1 << ADDR_W;
  localparam logic [USE_W-1:0] USE_MAX = '1;

  // line storage
  logic [ADDR_W-1:0] tagQ  [NUM_CACHES][ENTRIES];
  logic [DATA_W-1:0] dataQ [NUM_CACHES][ENTRIES];
  line_state_t       stQ   [NUM_CACHES][ENTRIES];
  logic [USE_W-1:0]  useQ  [NUM_CACHES][ENTRIES];
  logic [DATA_W-1:0] memQ  [MEM_DEPTH];

  // latched request
  logic [CPU_W-1:0]  cpuQ;
  logic              wrQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;

  logic [DATA_W-1:0] doneDataQ;
  logic              doneValidQ;
  logic [CNT_W-1:0]  memCntQ;

  // per-cache lookup
  logic [ENTRIES-1:0] matchVec [NUM_CACHES];
  logic [WAY_W-1:0]   hitWay   [NUM_CACHES];
  logic [NUM_CACHES-1:0] hasCopy;
  logic [NUM_CACHES-1:0] ownerMask;

  for (genvar c = 0; c < NUM_CACHES; c++) begin : gLookup
    for (genvar e = 0; e < ENTRIES; e++) begin : gWay
      assign matchVec[c][e] = (stQ[c][e] != ST_INV) && (tagQ[c][e] == addrQ);
    end
    always_comb begin
      hitWay[c] = '0;
      for (int e = 0; e < ENTRIES; e++)
        if (matchVec[c][e]) hitWay[c] = WAY_W'(e);
    end
    assign hasCopy[c]   = |matchVec[c];
    assign ownerMask[c] = hasCopy[c] &&
                          ((stQ[c][hitWay[c]] == ST_RESV) || (stQ[c][hitWay[c]] == ST_DIRTY));

    // a cache never holds two lines for one address
    AST_ONE_LINE_PER_ADDR: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(matchVec[c])); // R3
  end

  // requester view and remote dirty holder
  logic              ownHit;
  logic [WAY_W-1:0]  ownWay;
  line_state_t       ownState;
  logic [DATA_W-1:0] ownData;
  logic              otherDirty;
  logic [DATA_W-1:0] dirtyData;

  always_comb begin
    ownHit     = hasCopy[cpuQ];
    ownWay     = hitWay[cpuQ];
    ownState   = stQ[cpuQ][ownWay];
    ownData    = dataQ[cpuQ][ownWay];
    otherDirty = 1'b0;
    dirtyData  = '0;
    for (int c = 0; c < NUM_CACHES; c++) begin
      if (c != int'(cpuQ) && hasCopy[c] && stQ[c][hitWay[c]] == ST_DIRTY) begin
        otherDirty = 1'b1;
        dirtyData  = dataQ[c][hitWay[c]];
      end
    end
  end

  // victim choice: first invalid entry, else least used (lowest index on tie)
  logic [WAY_W-1:0]  victimWay;
  logic              foundFree;
  logic [USE_W-1:0]  minUse;
  line_state_t       victimState;
  logic [ADDR_W-1:0] victimTag;
  logic [DATA_W-1:0] victimData;

  always_comb begin
    foundFree = 1'b0;
    victimWay = '0;
    minUse    = useQ[cpuQ][0];
    for (int e = 0; e < ENTRIES; e++) begin
      if (!foundFree && stQ[cpuQ][e] == ST_INV) begin
        foundFree = 1'b1;
        victimWay = WAY_W'(e);
      end
    end
    if (!foundFree) begin
      for (int e = 1; e < ENTRIES; e++) begin
        if (useQ[cpuQ][e] < minUse) begin
          minUse    = useQ[cpuQ][e];
          victimWay = WAY_W'(e);
        end
      end
    end
    victimState = stQ[cpuQ][victimWay];
    victimTag   = tagQ[cpuQ][victimWay];
    victimData  = dataQ[cpuQ][victimWay];
  end

  assign flags.ownHit      = ownHit;
  assign flags.otherDirty  = otherDirty;
  assign flags.victimDirty = (victimState == ST_DIRTY);

  logic [WAY_W-1:0]  tgtWay;
  logic [DATA_W-1:0] fillData;
  logic              memTouch;

  assign tgtWay   = ownHit ? ownWay : victimWay;
  assign fillData = otherDirty ? dirtyData : memQ[addrQ];
  assign memTouch = strobe.evictWb || strobe.snoopWb ||
                    (strobe.commit && wrQ && ownHit && ownState == ST_VALID) ||
                    (strobe.commit && !wrQ && !ownHit && !otherDirty);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CACHES; c++) begin
        for (int e = 0; e < ENTRIES; e++) begin
          tagQ[c][e]  <= '0;
          dataQ[c][e] <= '0;
          stQ[c][e]   <= ST_INV;
          useQ[c][e]  <= '0;
        end
      end
      for (int m = 0; m < MEM_DEPTH; m++) memQ[m] <= '0;
      cpuQ       <= '0;
      wrQ        <= 1'b0;
      addrQ      <= '0;
      wdataQ     <= '0;
      doneDataQ  <= '0;
      doneValidQ <= 1'b0;
      memCntQ    <= '0;
    end else begin
      doneValidQ <= strobe.commit;
      if (memTouch) memCntQ <= memCntQ + 1'b1;

      if (strobe.latchReq) begin
        cpuQ   <= reqCpu;
        wrQ    <= reqWrite;
        addrQ  <= reqAddr;
        wdataQ <= reqData;
      end

      if (strobe.evictWb) memQ[victimTag] <= victimData;
      if (strobe.snoopWb) memQ[addrQ]     <= dirtyData;

      if (strobe.commit) begin
        // remote copies
        for (int c = 0; c < NUM_CACHES; c++) begin
          if (c != int'(cpuQ) && hasCopy[c]) begin
            if (wrQ)
              stQ[c][hitWay[c]] <= ST_INV;
            else if (!ownHit && stQ[c][hitWay[c]] != ST_VALID)
              stQ[c][hitWay[c]] <= ST_VALID;
          end
        end
        // requester line
        if (wrQ) begin
          tagQ[cpuQ][tgtWay]  <= addrQ;
          dataQ[cpuQ][tgtWay] <= wdataQ;
          if (ownHit && ownState == ST_VALID) begin
            stQ[cpuQ][tgtWay] <= ST_RESV;
            memQ[addrQ]       <= wdataQ;
          end else begin
            stQ[cpuQ][tgtWay] <= ST_DIRTY;
          end
        end else if (!ownHit) begin
          tagQ[cpuQ][tgtWay]  <= addrQ;
          dataQ[cpuQ][tgtWay] <= fillData;
          stQ[cpuQ][tgtWay]   <= ST_VALID;
        end
        if (ownHit) begin
          if (useQ[cpuQ][tgtWay] != USE_MAX)
            useQ[cpuQ][tgtWay] <= useQ[cpuQ][tgtWay] + 1'b1;
        end else begin
          useQ[cpuQ][tgtWay] <= USE_W'(1);
        end
        doneDataQ <= wrQ ? wdataQ : (ownHit ? ownData : fillData);
      end
    end
  end

  assign doneValid      = doneValidQ;
  assign doneData       = doneDataQ;
  assign memAccessCount = memCntQ;

  // at most one cache owns (reserved or dirty) the current address
  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ownerMask) <= 1); // R5

  AST_RD_HIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !wrQ && ownHit) |=> ($stable(memCntQ) && ownHit && ownState == $past(ownState))); // R2

  AST_WR_VALID_RESV: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && wrQ && ownHit && ownState == ST_VALID) |=> (ownHit && ownState == ST_RESV)); // R5

  AST_WR_LOCAL_DIRTY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && wrQ && ownHit && ownState != ST_VALID) |=> (ownState == ST_DIRTY && $stable(memCntQ))); // R6

  AST_WR_MISS_DIRTY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && wrQ && !ownHit) |=> (ownHit && ownState == ST_DIRTY && !otherDirty)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValidQ |=> !doneValidQ); // R11

endmodule

// File: rtl/woc_top.sv
module woc_top
  import woc_pkg::*;
#(
  parameter int NUM_CACHES = 3,
  parameter int ENTRIES    = 4,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int USE_W      = 3,
  parameter int CNT_W      = 16,
  localparam int CPU_W     = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [CPU_W-1:0]  reqCpu,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneData,
  output logic [CNT_W-1:0]  memAccessCount
);

  ctrl_strobe_t strobe;
  dp_flags_t    flags;

  woc_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .flags    (flags),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  woc_datapath #(
    .NUM_CACHES (NUM_CACHES),
    .ENTRIES    (ENTRIES),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .USE_W      (USE_W),
    .CNT_W      (CNT_W),
    .CPU_W      (CPU_W)
  ) uDp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .reqCpu         (reqCpu),
    .reqWrite       (reqWrite),
    .reqAddr        (reqAddr),
    .reqData        (reqData),
    .flags          (flags),
    .doneValid      (doneValid),
    .doneData       (doneData),
    .memAccessCount (memAccessCount)
  );

endmodule

// File: tb/tb_woc_top.sv
module tb_woc_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [1:0] reqCpu = '0;
  logic       reqWrite = 1'b0;
  logic [3:0] reqAddr = '0;
  logic [7:0] reqData = '0;
  logic       doneValid;
  logic [7:0] doneData;
  logic [15:0] memAccessCount;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0] expDataQ [$];
  int         expCntQ  [$];
  string      expTagQ  [$];

  always #5 clk = ~clk;

  woc_top dut (
    .clk            (clk),
    .rstN           (rstN),
    .reqValid       (reqValid),
    .reqReady       (reqReady),
    .reqCpu         (reqCpu),
    .reqWrite       (reqWrite),
    .reqAddr        (reqAddr),
    .reqData        (reqData),
    .doneValid      (doneValid),
    .doneData       (doneData),
    .memAccessCount (memAccessCount)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare each completion with the scoreboard
  logic prevDone = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (doneValid) begin
        if (prevDone) check(0, "R11 done longer than one cycle", 1, 0);
        if (expDataQ.size() == 0) begin
          check(0, "R11 unexpected completion", 1, 0);
        end else begin
          logic [7:0] ed;
          int ec;
          string et;
          ed = expDataQ.pop_front();
          ec = expCntQ.pop_front();
          et = expTagQ.pop_front();
          check(doneData == ed, {et, " data"}, doneData, ed);
          check(int'(memAccessCount) == ec, {et, " memory accesses"}, memAccessCount, ec);
        end
      end
      prevDone <= doneValid;
    end
  end

  // driver
  task automatic doReq(input int cpu, input bit wr, input int addr, input int data,
                       input int expData, input int expCnt, input string tag);
    expDataQ.push_back(8'(expData));
    expCntQ.push_back(expCnt);
    expTagQ.push_back(tag);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqCpu   = 2'(cpu);
    reqWrite = wr;
    reqAddr  = 4'(addr);
    reqData  = 8'(data);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R11 ready low while busy", reqReady, 0);
    @(posedge clk iff doneValid);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);
    check(doneValid == 1'b0, "R1 done low after reset", doneValid, 0);
    check(memAccessCount == 0, "R1 counter zero", memAccessCount, 0);
    rstN = 1'b1;
    // one address walked through all states
    doReq(0, 1, 1, 'h11, 'h11, 0, "R7 write miss no memory");
    doReq(1, 0, 1, 0,    'h11, 1, "R4 read miss from dirty cache");
    doReq(0, 0, 1, 0,    'h11, 1, "R2 read hit");
    doReq(0, 1, 1, 'h22, 'h22, 2, "R5 first write goes through");
    doReq(1, 0, 1, 0,    'h22, 3, "R3 R5 read miss from memory");
    doReq(0, 1, 1, 'h33, 'h33, 4, "R3 reserved demoted then written through");
    doReq(0, 1, 1, 'h44, 'h44, 4, "R6 write on reserved stays local");
    doReq(0, 1, 1, 'h55, 'h55, 4, "R6 write on dirty stays local");
    doReq(2, 1, 1, 'h66, 'h66, 5, "R8 write miss flushes remote dirty");
    doReq(0, 0, 1, 0,    'h66, 6, "R8 R4 old owner invalidated");
    // replacement in cache 1
    doReq(1, 0, 2, 0,    0,    7, "R10 fill free entry");
    doReq(1, 1, 3, 'hA3, 'hA3, 7, "R7 write miss to free entry");
    doReq(1, 0, 4, 0,    0,    8, "R12 fill");
    doReq(1, 0, 5, 0,    0,    9, "R12 fill");
    doReq(1, 0, 2, 0,    0,    9, "R2 hit raises use");
    doReq(1, 0, 4, 0,    0,    9, "R2 hit raises use");
    doReq(1, 0, 5, 0,    0,    9, "R2 hit raises use");
    doReq(1, 0, 6, 0,    0,   11, "R9 R10 dirty least-used victim written back");
    doReq(2, 0, 3, 0,    'hA3,12, "R9 written-back byte in memory");
    doReq(1, 0, 7, 0,    0,   13, "R9 R10 valid victim dropped silently");
    doReq(1, 0, 2, 0,    0,   13, "R10 frequently used entry kept");
    doReq(1, 1, 3, 'hB3, 'hB3,13, "R7 write miss invalidates remote valid copy");
    doReq(2, 0, 3, 0,    'hB3,14, "R7 remote copy was invalidated");
    check(expDataQ.size() == 0, "R11 all completions seen", expDataQ.size(), 0);
    finished = 1;
  end

  initial begin
    int cycles;
    cycles = 0;
    while (!finished && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) check(0, "R11 watchdog expired", cycles, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule